// File: doc/BRIEF.md
# Accumulator ALU with Stored Carry Flag

This block is the arithmetic and logic stage that sits beside a narrow accumulator. It combines the accumulator value with a second operand and offers four functions: add or subtract, bitwise AND, pass-through of the second operand, and rotate-right of the accumulator through a carry bit. A 3-bit control code picks one function, and its output goes onto the result bus. The result is combinational: it is valid in the same cycle as the inputs, so the accumulator register outside the block can capture it at the next clock edge.

The carry is kept in a flip-flop rather than taken from the datapath, so it stays valid after the operands change when the next instruction is fetched. The flop loads only on a clock edge where three conditions hold: the accumulator is being written, the instruction decoder marks the operation as one that may change flags, and the function selected is add/sub or rotate. The stored carry is also the bit that rotate-right shifts into the most significant position. This lets a program chain rotates across several bytes, for example in a shift-and-add multiply.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `carry_o` is 0. After reset is released it stays 0 until the first qualified carry update.
- R2: Control code 3'b000 (add) drives `res_o` = (`acc_i` + `opd_i`) mod 2^W. On a qualified update, `carry_o` after the edge is bit W of the full sum.
- R3: Control code 3'b001 (subtract) drives `res_o` = (`acc_i` − `opd_i`) mod 2^W. On a qualified update, the new `carry_o` is the carry-out of `acc_i` + ~`opd_i` + 1. That carry is 1 exactly when `acc_i` ≥ `opd_i`.
- R4: Control codes 3'b010 and 3'b011 drive `res_o` = `acc_i` & `opd_i`.
- R5: Control codes 3'b100 and 3'b101 drive `res_o` = `opd_i`.
- R6: Control codes 3'b110 and 3'b111 (bit 0 ignored) drive `res_o` = {`carry_o`, `acc_i`[W-1:1]}. On a qualified update, the new `carry_o` is `acc_i`[0].
- R7: The carry flag changes only on a rising clock edge where `acc_we_i` = 1, `flag_op_i` = 1 and the control code selects add, subtract or rotate. In every other cycle it holds its value.
- R8: AND and pass-through leave `carry_o` unchanged, even when `acc_we_i` and `flag_op_i` are both 1.
- R9: The result path holds no state. `res_o` follows the inputs and the stored carry within the same cycle.
- R10: Starting from 0x11 with carry 0, two rotates in a row, each fed back as the accumulator, give 0x08 with carry 1 and then 0x84 with carry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it internally in step with the clock |
| acc_i | input | W | Accumulator operand |
| opd_i | input | W | Second operand (immediate or memory data) |
| ctl_i | input | 3 | Function select: 00x add/sub (bit 0 = subtract), 01x AND, 10x pass, 11x rotate right |
| acc_we_i | input | 1 | Accumulator write enable; also the clock enable of the carry flop |
| flag_op_i | input | 1 | Decoder qualifier: 1 for instructions allowed to change flags |
| res_o | output | W | Combinational result |
| carry_o | output | 1 | Stored carry flag |

## Verification
The bench builds the block with its default W = 8. At that width the operand space is small enough that uniformly random operands often land on the interesting values: all-ones sums that carry, equal operands in subtraction, and zero operands. The bench adds directed cases for those values, for subtract with and without borrow, for rotate chains through the carry, and for updates blocked by each of the three qualifying conditions. Its reference model recomputes the sum and the difference at W+1 bits, so the carry bit it expects does not depend on the ripple chain in the design.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [1:0] {
    FN_ADDSUB = 2'b00,
    FN_AND    = 2'b01,
    FN_PASS   = 2'b10,
    FN_ROTR   = 2'b11
  } alu_fn_e;

  // upper two control bits select the function; bit 0 is the subtract modifier
  function automatic alu_fn_e fn_of(input logic [2:0] ctl);
    return alu_fn_e'(ctl[2:1]);
  endfunction

  function automatic logic fn_sets_carry(input alu_fn_e fn);
    return (fn == FN_ADDSUB) || (fn == FN_ROTR);
  endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W:0] chain;

  assign chain[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic b_eff;
    logic prop;
    assign b_eff       = b_i[i] ^ sub_i;
    assign prop        = a_i[i] ^ b_eff;
    assign sum_o[i]    = prop ^ chain[i];
    assign chain[i+1]  = (a_i[i] & b_eff) | (prop & chain[i]);
  end

  assign cout_o = chain[W];

endmodule

// File: rtl/acc_alu_rotr.sv
module acc_alu_rotr #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] y_o,
  output logic         cout_o
);

  for (genvar i = 0; i < W - 1; i++) begin : g_shift
    assign y_o[i] = a_i[i+1];
  end

  assign y_o[W-1] = cin_i;
  assign cout_o   = a_i[0];

endmodule

// File: rtl/acc_alu_carry_reg.sv
module acc_alu_carry_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en_i,
  input  logic d_i,
  output logic q_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       carry_q;
  logic       carry_d;

  // asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    carry_d = carry_q;
    if (upd_en_i) begin
      carry_d = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      carry_q <= 1'b0;
    end else begin
      carry_q <= carry_d;
    end
  end

  assign q_o = carry_q;

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opd_i,
  input  logic [2:0]   ctl_i,
  input  logic         acc_we_i,
  input  logic         flag_op_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);

  import acc_alu_pkg::*;

  alu_fn_e     fn;
  logic [W-1:0] add_y;
  logic         add_c;
  logic [W-1:0] rot_y;
  logic         rot_c;
  logic         carry_q;
  logic         carry_src;
  logic         carry_upd;

  assign fn = fn_of(ctl_i);

  acc_alu_addsub #(.W(W)) u_addsub (
    .a_i    (acc_i),
    .b_i    (opd_i),
    .sub_i  (ctl_i[0]),
    .sum_o  (add_y),
    .cout_o (add_c)
  );

  acc_alu_rotr #(.W(W)) u_rotr (
    .a_i    (acc_i),
    .cin_i  (carry_q),
    .y_o    (rot_y),
    .cout_o (rot_c)
  );

  // four-input result multiplexer
  always_comb begin
    unique case (fn)
      FN_ADDSUB: res_o = add_y;
      FN_AND:    res_o = acc_i & opd_i;
      FN_PASS:   res_o = opd_i;
      FN_ROTR:   res_o = rot_y;
      default:   res_o = add_y;
    endcase
  end

  // carry source select and update qualifier
  always_comb begin
    carry_src = (fn == FN_ROTR) ? rot_c : add_c;
    carry_upd = acc_we_i & flag_op_i & fn_sets_carry(fn);
  end

  acc_alu_carry_reg u_carry (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en_i (carry_upd),
    .d_i      (carry_src),
    .q_o      (carry_q)
  );

  assign carry_o = carry_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opd_i,
  input logic [2:0]   ctl_i,
  input logic         acc_we_i,
  input logic         flag_op_i,
  input logic [W-1:0] res_o,
  input logic         carry_o
);

  logic [W:0] wide_sum;
  logic [W:0] wide_diff;
  logic       qual;

  assign wide_sum  = {1'b0, acc_i} + {1'b0, opd_i};
  assign wide_diff = {1'b0, acc_i} + {1'b0, ~opd_i} + {{W{1'b0}}, 1'b1};
  assign qual      = acc_we_i & flag_op_i;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (carry_o == 1'b0);
    end
  end

  assert_add_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && ctl_i == 3'b000) |=> carry_o == $past(wide_sum[W]));

  assert_sub_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && ctl_i == 3'b001) |=> carry_o == $past(wide_diff[W]));

  assert_rotr_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i[2:1] == 2'b11) |-> (res_o == {carry_o, acc_i[W-1:1]}));

  assert_rotr_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && ctl_i[2:1] == 2'b11) |=> carry_o == $past(acc_i[0]));

  assert_hold_unqualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> $stable(carry_o));

  assert_logic_keeps_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i[2:1] == 2'b01 || ctl_i[2:1] == 2'b10) |=> $stable(carry_o));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_acc_alu_chk (.*);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] acc_i;
  logic [W-1:0] opd_i;
  logic [2:0]   ctl_i;
  logic         acc_we_i;
  logic         flag_op_i;
  logic [W-1:0] res_o;
  logic         carry_o;

  int checks;
  int fails;
  logic model_c;
  bit done;

  acc_alu #(.W(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_i     (acc_i),
    .opd_i     (opd_i),
    .ctl_i     (ctl_i),
    .acc_we_i  (acc_we_i),
    .flag_op_i (flag_op_i),
    .res_o     (res_o),
    .carry_o   (carry_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] exp_res(input logic [2:0] c, input logic [W-1:0] a,
                                            input logic [W-1:0] b, input logic cf);
    logic [W:0] t;
    case (c[2:1])
      2'b00: begin
        t = c[0] ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        return t[W-1:0];
      end
      2'b01: return a & b;
      2'b10: return b;
      default: return {cf, a[W-1:1]};
    endcase
  endfunction

  function automatic logic exp_carry(input logic [2:0] c, input logic [W-1:0] a,
                                     input logic [W-1:0] b, input logic we,
                                     input logic fo, input logic cf);
    logic [W:0] t;
    if (!(we && fo)) return cf;
    case (c[2:1])
      2'b00: begin
        if (c[0]) return (a >= b);
        t = {1'b0, a} + {1'b0, b};
        return t[W];
      end
      2'b11: return a[0];
      default: return cf;
    endcase
  endfunction

  function automatic string res_tag(input logic [2:0] c);
    case (c[2:1])
      2'b00: return c[0] ? "R3" : "R2";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // drive at negedge, check result before the edge (R9), carry after it
  task automatic apply(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic we, input logic fo, input string ctag);
    logic nxt;
    @(negedge clk);
    ctl_i = c; acc_i = a; opd_i = b; acc_we_i = we; flag_op_i = fo;
    #1;
    check({res_tag(c), "/R9 result"}, {1'b0, res_o}, {1'b0, exp_res(c, a, b, model_c)});
    nxt = exp_carry(c, a, b, we, fo, model_c);
    @(posedge clk);
    #1;
    check({ctag, " carry"}, {{W{1'b0}}, carry_o}, {{W{1'b0}}, nxt});
    model_c = nxt;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [W-1:0] racc;
    logic [2:0]   rctl;
    logic         rwe;
    logic         rfo;
    string        tg;
    void'($urandom(32'h5A17));
    checks = 0; fails = 0; done = 1'b0; model_c = 1'b0;
    rst_n = 1'b0; acc_i = '0; opd_i = '0; ctl_i = 3'b000; acc_we_i = 1'b0; flag_op_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", {{W{1'b0}}, carry_o}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after release", {{W{1'b0}}, carry_o}, '0);

    // R10 rotate sequence from 0x11, carry 0
    apply(3'b000, 8'h00, 8'h00, 1'b1, 1'b1, "R2");
    apply(3'b110, 8'h11, 8'h00, 1'b1, 1'b1, "R10");
    check("R10 first rotate", {1'b0, 8'h08}, {1'b0, exp_res(3'b110, 8'h11, 8'h00, 1'b0)});
    check("R10 carry after first", {8'h00, carry_o}, 9'h001);
    apply(3'b111, 8'h08, 8'h00, 1'b1, 1'b1, "R10");
    @(negedge clk); ctl_i = 3'b110; acc_i = 8'h00; #1;
    check("R10 msb from carry", {1'b0, res_o}, 9'h000);
    apply(3'b110, 8'h01, 8'h00, 1'b1, 1'b1, "R6");
    apply(3'b110, 8'h08, 8'h00, 1'b1, 1'b1, "R6");
    check("R10 second rotate value", {1'b0, 8'h84}, {1'b0, exp_res(3'b110, 8'h08, 8'h00, 1'b1)});

    // add corners
    apply(3'b000, 8'hFF, 8'h01, 1'b1, 1'b1, "R2");
    check("R2 overflow carry set", {8'h00, carry_o}, 9'h001);
    apply(3'b000, 8'h7F, 8'h80, 1'b1, 1'b1, "R2");
    check("R2 no overflow carry clear", {8'h00, carry_o}, 9'h000);
    // subtract corners
    apply(3'b001, 8'h05, 8'h05, 1'b1, 1'b1, "R3");
    check("R3 equal no borrow", {8'h00, carry_o}, 9'h001);
    apply(3'b001, 8'h00, 8'h01, 1'b1, 1'b1, "R3");
    check("R3 borrow clears", {8'h00, carry_o}, 9'h000);
    apply(3'b001, 8'h10, 8'h00, 1'b1, 1'b1, "R3");
    // AND / pass keep carry set
    apply(3'b010, 8'hF0, 8'h3C, 1'b1, 1'b1, "R8");
    apply(3'b011, 8'hAA, 8'h55, 1'b1, 1'b1, "R8");
    apply(3'b100, 8'h12, 8'h00, 1'b1, 1'b1, "R8");
    apply(3'b101, 8'h00, 8'hE7, 1'b1, 1'b1, "R8");
    check("R8 carry still set", {8'h00, carry_o}, 9'h001);
    // blocked updates: each qualifier missing
    apply(3'b000, 8'h01, 8'h01, 1'b0, 1'b1, "R7");
    apply(3'b110, 8'h02, 8'h00, 1'b1, 1'b0, "R7");
    apply(3'b001, 8'h00, 8'h01, 1'b0, 1'b0, "R7");
    check("R7 carry held", {8'h00, carry_o}, 9'h001);

    // random mix
    for (int i = 0; i < 600; i++) begin
      racc = W'($urandom);
      rctl = 3'($urandom);
      rwe  = ($urandom_range(0, 9) < 8);
      rfo  = ($urandom_range(0, 9) < 8);
      if (!(rwe && rfo)) tg = "R7";
      else if (rctl[2:1] == 2'b01 || rctl[2:1] == 2'b10) tg = "R8";
      else tg = res_tag(rctl);
      apply(rctl, racc, W'($urandom), rwe, rfo, tg);
    end

    // reset mid-run clears carry
    apply(3'b000, 8'hFF, 8'hFF, 1'b1, 1'b1, "R2");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", {8'h00, carry_o}, 9'h000);
    finish_up();
  end

endmodule